// File: doc/BRIEF.md
# Sequential Combination Lock

A clocked state machine models a dial lock that opens only when three dial operations arrive in the right order. Each operation turns the dial in one direction (right or left) and stops at a number. An operation arrives as one valid-qualified input per clock cycle. The machine tracks progress through four states held in a two-bit register: no progress, first step done, second step done, and open. The unlock output is decoded from the current state alone, so the machine is a Moore machine. The output changes only at a clock edge and never follows the inputs directly.

The required order is right to 13, then left to 22, then right to 3. Any valid operation that breaks the order drops progress. The one exception is right-13: it always counts as a fresh first step. Idle cycles keep the progress that has been made. Once the lock is open, it ignores further dial operations and stays open until a relock request closes it.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the machine enters the no-progress state (encoding 00), and `unlocked` is low in the next cycle.
- R2: `unlocked` is high exactly when the state is open (encoding 11), and it changes only at a clock edge. It can only rise on the edge that takes in a valid right-3 operation.
- R3: A cycle with `op_valid` low and `relock` low leaves the state unchanged.
- R4: Three valid operations in the order right-13, left-22, right-3 open the lock. Idle cycles may come between them. Direction encoding is `op_dir`=1 for right and 0 for left.
- R5: A valid operation that is not the next expected step returns the machine to the no-progress state. The values the lock accepts are the same, but their order decides whether it opens.
- R6: A mismatching valid operation that is right-13 leaves the machine in the first-step state rather than the no-progress state. This holds even as a repeat of the first step.
- R7: While open, valid dial operations have no effect and `unlocked` stays high.
- R8: While open, `relock` high at a clock edge returns the machine to the no-progress state. `relock` takes priority over a valid operation in the same cycle.
- R9: Outside the open state, `relock` is ignored and progress is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Qualifies the dial operation in this cycle |
| op_dir | input | 1 | Dial direction: 1 right, 0 left |
| op_num | input | 6 | Dial number of the operation |
| relock | input | 1 | Close request, acted on only while open |
| unlocked | output | 1 | High while the lock is open |

## Verification
The lock is driven with several kinds of sequence:
- The correct sequence, with and without idle gaps between steps.
- Sequences that contain the right values in the wrong order. These show that order matters, not just the values.
- Near-misses, where the direction or the number of a step is wrong. These separate a direction compare from a number compare.
- Repeated or restarted first steps mixed in at each stage, which show the right-13 restart path apart from the plain fallback to no progress.
- Relock requests sent outside the open state and inside it, some of them together with a dial operation, which check both the scope of the relock and its priority.

A behavioural progress counter in the bench predicts `unlocked` on every cycle.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_GOT1 = 2'b01,
    ST_GOT2 = 2'b10,
    ST_OPEN = 2'b11
  } lock_state_e;

  localparam int unsigned NUM_STEPS = 3;
endpackage

// File: rtl/lock_step_match.sv
module lock_step_match
  import lock_pkg::*;
#(
  parameter int unsigned DIAL_W = 6,
  parameter logic [NUM_STEPS-1:0] STEP_DIR = 3'b101,
  parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUM = {6'd3, 6'd22, 6'd13}
) (
  input  logic              op_dir,
  input  logic [DIAL_W-1:0] op_num,
  output logic [NUM_STEPS-1:0] hit
);
  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    assign hit[i] = (op_dir == STEP_DIR[i]) &&
                    (op_num == STEP_NUM[i*DIAL_W +: DIAL_W]);
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e          cur,
  input  logic                 op_valid,
  input  logic                 relock,
  input  logic [NUM_STEPS-1:0] hit,
  output lock_state_e          nxt
);
  lock_state_e fallback;

  always_comb begin
    fallback = hit[0] ? ST_GOT1 : ST_IDLE;
    nxt = cur;
    unique case (cur)
      ST_IDLE: if (op_valid) nxt = fallback;
      ST_GOT1: if (op_valid) nxt = hit[1] ? ST_GOT2 : fallback;
      ST_GOT2: if (op_valid) nxt = hit[2] ? ST_OPEN : fallback;
      ST_OPEN: if (relock)   nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int unsigned DIAL_W = 6,
  parameter logic [NUM_STEPS-1:0] STEP_DIR = 3'b101,
  parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUM = {6'd3, 6'd22, 6'd13}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic              op_dir,
  input  logic [DIAL_W-1:0] op_num,
  input  logic              relock,
  output logic              unlocked
);
  localparam int unsigned LAST = NUM_STEPS - 1;

  lock_state_e          state_q, state_d;
  logic [NUM_STEPS-1:0] hit;

  lock_step_match #(
    .DIAL_W  (DIAL_W),
    .STEP_DIR(STEP_DIR),
    .STEP_NUM(STEP_NUM)
  ) u_match (
    .op_dir(op_dir),
    .op_num(op_num),
    .hit   (hit)
  );

  lock_next_state u_next (
    .cur     (state_q),
    .op_valid(op_valid),
    .relock  (relock),
    .hit     (hit),
    .nxt     (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign unlocked = (state_q == ST_OPEN);

  // R1: reset lands in the no-progress state
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && !unlocked));

  // R2: opening only follows a valid final step
  a_r2_open_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(op_valid && op_dir == STEP_DIR[LAST] &&
                              op_num == STEP_NUM[LAST*DIAL_W +: DIAL_W]));

  // R3: idle cycles hold the state
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> $stable(state_q));

  // R7: open persists without relock
  a_r7_open_holds: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !relock) |=> unlocked);

  // R8: relock closes an open lock
  a_r8_relock_closes: assert property (@(posedge clk) disable iff (rst)
    (unlocked && relock) |=> (state_q == ST_IDLE));

  // R6: a right-13 outside the open state always yields first-step progress
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !unlocked && hit[0]) |=> (state_q == ST_GOT1));
endmodule

// File: tb/combo_lock_bench.sv
module combo_lock_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic       op_dir = 1'b0;
  logic [5:0] op_num = 6'd0;
  logic       relock = 1'b0;
  logic       unlocked;

  int vectors = 0;
  int errors  = 0;
  int prog    = 0;
  bit done    = 0;

  int exp_dir [3] = '{1, 0, 1};
  int exp_num [3] = '{13, 22, 3};

  always #4 clk = ~clk;

  combo_lock u_combo_lock (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_dir(op_dir),
    .op_num(op_num), .relock(relock), .unlocked(unlocked)
  );

  function automatic bit is_step(int k, bit d, int n);
    return (int'(d) == exp_dir[k]) && (n == exp_num[k]);
  endfunction

  task automatic cyc(bit r, bit v, bit d, int n, bit rl, string req);
    @(negedge clk);
    rst = r; op_valid = v; op_dir = d; op_num = n[5:0]; relock = rl;
    if (r) prog = 0;
    else if (prog == 3) begin
      if (rl) prog = 0;
    end else if (v) begin
      if (is_step(prog, d, n)) prog = prog + 1;
      else if (is_step(0, d, n)) prog = 1;
      else prog = 0;
    end
    @(posedge clk);
    #1;
    vectors++;
    if (unlocked !== (prog == 3)) begin
      errors++;
      $display("FAIL %s: unlocked=%b expected=%b", req, unlocked, prog == 3);
    end
  endtask

  task automatic op(bit d, int n, string req);
    cyc(0, 1, d, n, 0, req);
  endtask

  task automatic idle(string req);
    cyc(0, 0, 0, 0, 0, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: unlocked=%b expected=finish", unlocked);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, 0, 0, 0, "R1");
    cyc(1, 1, 1, 13, 1, "R1");
    idle("R3");
    // R4 straight sequence, then R7 ignore, R8 relock
    op(1, 13, "R4"); op(0, 22, "R4"); op(1, 3, "R4");
    op(1, 13, "R7"); op(0, 5, "R7"); op(1, 3, "R7"); idle("R7");
    cyc(0, 1, 1, 13, 1, "R8");
    idle("R8");
    // R4 with gaps, R3 holding
    op(1, 13, "R3"); idle("R3"); idle("R3"); op(0, 22, "R3");
    idle("R3"); op(1, 3, "R4");
    cyc(0, 0, 0, 0, 1, "R8");
    // R5 wrong order of the right values
    op(0, 22, "R5"); op(1, 13, "R5"); op(1, 3, "R5");
    op(1, 3, "R5"); op(0, 22, "R5"); op(1, 13, "R5"); op(1, 3, "R5");
    // R5 near misses: direction and number
    op(1, 13, "R5"); op(1, 22, "R5"); op(1, 3, "R5");
    op(1, 13, "R5"); op(0, 22, "R5"); op(0, 3, "R5"); op(1, 3, "R5");
    op(0, 13, "R5"); op(0, 22, "R5"); op(1, 3, "R5");
    op(1, 13, "R5"); op(0, 23, "R5"); op(1, 3, "R5");
    // R6 restart on right-13 at each stage
    op(1, 13, "R6"); op(1, 13, "R6"); op(0, 22, "R6"); op(1, 3, "R6");
    cyc(0, 0, 0, 0, 1, "R8");
    op(1, 13, "R6"); op(0, 22, "R6"); op(1, 13, "R6");
    op(0, 22, "R6"); op(1, 3, "R6");
    cyc(0, 0, 0, 0, 1, "R8");
    // R9 relock outside open ignored
    cyc(0, 0, 0, 0, 1, "R9"); op(1, 13, "R9");
    cyc(0, 0, 0, 0, 1, "R9"); op(0, 22, "R9");
    cyc(0, 0, 0, 0, 1, "R9"); op(1, 3, "R9");
    // R1 reset from open and mid sequence
    cyc(1, 0, 0, 0, 0, "R1"); idle("R1");
    op(1, 13, "R1"); op(0, 22, "R1");
    cyc(1, 0, 0, 0, 0, "R1"); op(1, 3, "R1");
    // R2 open only on the final step edge
    op(1, 13, "R2"); op(0, 22, "R2"); idle("R2"); op(1, 3, "R2");
    idle("R2");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule